// File: doc/BRIEF.md
# End-Marked String Recogniser

This block watches a stream of 2-bit symbols, one per clock, drawn from a four-letter alphabet: the letters `a` and `b`, a start marker and an end marker. A string is framed by a leading start marker and a trailing end marker. The block raises a single accept bit when the letter just before the end marker was `a`, and holds that bit until the next start marker arrives.

The machine has no reset pin. Its two flip-flops may wake up holding any value, including a code that no legal sequence ever reaches. The start marker pulls the machine into its initial state from every state, so every framed string brings its own synchronisation. The output is a pure function of the stored state, a Moore arrangement. This means accept changes only at a clock edge. The next-state logic uses two short equations. They rely on the symbols that can never arrive in the accept state or in the power-up spare state being treated as don't-cares.

Top module: `endmark_recognizer`

## Requirements
- R1: The symbol code on `sym[1:0]` is 00 for start, 01 for `a`, 10 for `b` and 11 for end. One symbol is consumed at each rising clock edge, and `accept` shows its effect just after that edge.
- R2: A start symbol in any state, including the unused power-up state, brings the machine to its initial state, and `accept` is low in the following cycle.
- R3: The letter `a`, received in the initial state or in the last-was-`a` state, moves the machine to the last-was-`a` state with `accept` low.
- R4: The letter `b`, received in the initial state or in the last-was-`a` state, returns the machine to the initial state with `accept` low.
- R5: An end symbol in the last-was-`a` state enters the accept state, and `accept` is high from the next cycle on.
- R6: An end symbol in the initial state leaves the machine in the initial state with `accept` low. A following `a` and end symbol then still produce acceptance.
- R7: `accept` depends only on the stored state. A change on `sym` between clock edges does not alter `accept` before the next edge.
- R8: The sequence start, b, a, b, a, end produces `accept` values 0,0,0,0,1 after the five symbols that follow the start.
- R9: There is no reset input. Behaviour from the first start symbol onward does not depend on any symbols received before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one symbol consumed per rising edge |
| sym | input | 2 | Symbol code: 00 start, 01 a, 10 b, 11 end |
| accept | output | 1 | High while in the accept state |

## Verification
The block has no size parameters. The bench builds it with its fixed 2-bit symbol and state widths, so the entire state space of four codes is within reach. Before the first start marker, and again between test groups, the bench drives random non-start preambles. These leave the flip-flops in arbitrary values, which exercises resynchronisation from history that cannot be predicted. Random framed strings of varied length, together with directed empty frames and an end-from-initial case, cover every defined transition.

// File: rtl/sr_pkg.sv
// Shared codes for the end-marked string recogniser.
// Assumes: 2-bit symbol and 2-bit state codes as listed; the accept
// state is the only code with both bits set.
package sr_pkg;
    localparam int SYM_W = 2;
    localparam int ST_W  = 2;

    typedef enum logic [SYM_W-1:0] {
        SYM_SOS = 2'b00,
        SYM_A   = 2'b01,
        SYM_B   = 2'b10,
        SYM_EOS = 2'b11
    } sym_e;

    typedef enum logic [ST_W-1:0] {
        ST_SPARE  = 2'b00,
        ST_IDLE   = 2'b01,
        ST_SAW_A  = 2'b10,
        ST_ACCEPT = 2'b11
    } state_e;
endpackage

// File: rtl/sr_next_state.sv
// Next-state equations for the recogniser.
// Assumes: non-start symbols never arrive in the spare or accept state,
// so those transitions are free and the logic reduces to two terms.
module sr_next_state
    import sr_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    input  logic [ST_W-1:0]  cur,
    output logic [ST_W-1:0]  nxt
);
    // Low bit set by start, b and end; high bit by a, or by end when high bit already set.
    always_comb begin
        nxt[0] = ~sym[0] | sym[1];
        nxt[1] = (~sym[1] | cur[1]) & sym[0];
    end
endmodule

// File: rtl/sr_state_reg.sv
// State storage with no reset; powers up with whatever value it holds.
// Assumes: a start symbol upstream provides synchronisation.
module sr_state_reg
    import sr_pkg::*;
(
    input  logic            clk,
    input  logic [ST_W-1:0] d,
    output logic [ST_W-1:0] q
);
    // Capture the next state on every rising edge.
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/sr_accept_decode.sv
// Moore output decode: accept is asserted only in the accept state.
// Assumes: accept state is the single code with both bits high.
module sr_accept_decode
    import sr_pkg::*;
(
    input  logic [ST_W-1:0] cur,
    output logic            accept
);
    // Both state bits high marks acceptance.
    always_comb begin
        accept = cur[1] & cur[0];
    end
endmodule

// File: rtl/endmark_recognizer.sv
// Top of the end-marked string recogniser: accepts framed strings whose
// final letter before the end marker is 'a'. No reset pin; the start
// marker resynchronises from any state.
module endmark_recognizer
    import sr_pkg::*;
(
    input  logic       clk,
    input  logic [1:0] sym,
    output logic       accept
);
    logic [ST_W-1:0] state_q;
    logic [ST_W-1:0] state_d;

    sr_next_state u_next (
        .sym (sym),
        .cur (state_q),
        .nxt (state_d)
    );

    sr_state_reg u_reg (
        .clk (clk),
        .d   (state_d),
        .q   (state_q)
    );

    sr_accept_decode u_dec (
        .cur    (state_q),
        .accept (accept)
    );

    // R2
    sos_to_idle_chk: assert property (@(posedge clk)
        sym == SYM_SOS |=> (state_q == ST_IDLE && !accept));

    // R3
    a_to_saw_a_chk: assert property (@(posedge clk)
        (sym == SYM_A && (state_q == ST_IDLE || state_q == ST_SAW_A))
        |=> (state_q == ST_SAW_A && !accept));

    // R4
    b_to_idle_chk: assert property (@(posedge clk)
        (sym == SYM_B && (state_q == ST_IDLE || state_q == ST_SAW_A))
        |=> (state_q == ST_IDLE && !accept));

    // R5
    eos_accept_chk: assert property (@(posedge clk)
        (sym == SYM_EOS && state_q == ST_SAW_A) |=> accept);

    // R6
    eos_idle_hold_chk: assert property (@(posedge clk)
        (sym == SYM_EOS && state_q == ST_IDLE) |=> (state_q == ST_IDLE && !accept));

    // R7
    accept_stable_chk: assert property (@(posedge clk)
        (state_q == ST_ACCEPT && sym == SYM_EOS) |=> accept);
endmodule

// File: tb/test_endmark_recognizer.sv
module test_endmark_recognizer;
    logic       clk = 1'b0;
    logic [1:0] sym = 2'b10;
    logic       accept;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Behavioural reference state
    bit framed = 0;
    bit last_a = 0;
    bit acc    = 0;

    endmark_recognizer i_endmark_recognizer (
        .clk    (clk),
        .sym    (sym),
        .accept (accept)
    );

    always #5 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: accept=%0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive one symbol, confirm output ignores the input change (R7), then compare after the edge.
    task automatic step(input logic [1:0] s, input string tag);
        sym = s;
        #2;
        if (framed) check(accept, acc, "R7 output moved with input");
        @(posedge clk);
        #1;
        case (s)
            2'b00: begin framed = 1; last_a = 0; acc = 0; end
            2'b01: begin last_a = 1; acc = 0; end
            2'b10: begin last_a = 0; acc = 0; end
            default: begin acc = last_a; last_a = 0; end
        endcase
        if (framed) check(accept, acc, tag);
    endtask

    task automatic preamble(input int n);
        framed = 0;
        for (int i = 0; i < n; i++) begin
            logic [1:0] r;
            r = 2'($urandom_range(1, 3));
            step(r, "pre");
        end
    endtask

    function automatic string tag_for(input logic [1:0] s, input bit la);
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return la ? "R5" : "R6";
        endcase
    endfunction

    initial begin
        // R9: arbitrary history, then the first start must synchronise
        preamble(7);
        step(2'b00, "R9 first start after random history");

        // R8 / R1: directed sequence with outputs 0,0,0,0,1
        step(2'b10, "R8 b");
        step(2'b01, "R8 a");
        step(2'b10, "R8 b");
        step(2'b01, "R8 a");
        step(2'b11, "R8 end (R1 codes)");
        check(accept, 1'b1, "R1 accept after a,end");

        // R6: empty frame, end in initial state, then a and end accept
        step(2'b00, "R2");
        step(2'b11, "R6 end in initial");
        check(accept, 1'b0, "R6 accept stays low");
        step(2'b01, "R6 a after end");
        step(2'b11, "R6 end after a");
        check(accept, 1'b1, "R6 later acceptance");

        // R5: accept held until next start
        step(2'b00, "R2 start clears accept");

        // Random groups, each preceded by random history (R9)
        for (int g = 0; g < 20; g++) begin
            preamble(int'($urandom_range(1, 5)));
            step(2'b00, "R9 resync");
            for (int f = 0; f < 8; f++) begin
                int len;
                len = int'($urandom_range(0, 6));
                if (f > 0) step(2'b00, "R2");
                for (int k = 0; k < len; k++) begin
                    logic [1:0] l;
                    l = ($urandom_range(0, 1) == 1) ? 2'b01 : 2'b10;
                    step(l, tag_for(l, last_a));
                end
                step(2'b11, tag_for(2'b11, last_a));
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: accept=%0b expected completion", accept);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule